// File: doc/BRIEF.md
# Staged Boot Bring-Up Sequencer with Bounded Retry

This block brings a processor subsystem out of reset once power and clocks are reported good. It first lets the graphics device out of reset and waits for that device to report that its reset has finished. It then waits for the interconnect link between the devices to reach the L0 state, and only then lets the CPU out of reset. Last, it waits for the first request from boot software asking why the system powered up. Each of these three waits has its own cycle budget. An expired budget is a boot-class failure.

After a failure, both reset lines are driven again and held for a minimum number of cycles. The sequence then starts over from the graphics release step. While the CPU is running and the handshake is still pending, software may report a memory-initialisation failure with a code from 0x10 to 0x15. Such a report is handled like a boot failure and draws on the same retry budget. The attempt counter is cleared only by the block's reset. When the final allowed attempt fails, the block halts with both resets asserted and shows the code of the step that failed. A successful handshake raises a done flag, and from then on the block is fixed in the running state.

Top module: `boot_seq_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `gfx_reset` and `cpu_reset` are 1, `boot_done` and `halted` are 0, and `err_code` is 0x00.
- R2: While `pwr_clk_ok` is low in the initial wait, both reset outputs stay at 1 indefinitely.
- R3: One cycle after `pwr_clk_ok` is sampled high, `gfx_reset` goes to 0 while `cpu_reset` stays at 1. `cpu_reset` stays at 1 after `gfx_rst_done` is seen, until `link_l0` is also seen.
- R4: `cpu_reset` goes to 0 one cycle after `link_l0` is sampled high in the link wait. `boot_done` goes to 1 one cycle after `hs_req` is sampled high in the handshake wait.
- R5: When a wait sees no response, both resets return to 1 exactly GFX_TMO, LINK_TMO or HS_TMO cycles after that wait began. At the same edge `err_code` becomes 0x08 (no reset-done), 0x09 (no L0) or 0x0A (no handshake).
- R6: After a failure that is not the last allowed one, both resets stay at 1 for exactly HOLD_CYC cycles, with `pwr_clk_ok` high. Then `gfx_reset` is released again and the sequence restarts from the graphics step.
- R7: At most MAX_RETRY+1 attempts (5 by default) are made. The attempt count survives between attempts and is cleared only by `rst`. When the final attempt fails, `halted` becomes 1, both resets stay at 1, and `err_code` holds that failure's code.
- R8: In the handshake wait, `sw_err_vld` with `sw_err_code` in 0x10 to 0x15 is a failure. Both resets return to 1 the next cycle and `err_code` takes that code. Codes outside that range are ignored.
- R9: Once `boot_done` is 1, all stage inputs and software reports are ignored. Both resets stay at 0 and `err_code` is unchanged.
- R10: Once `halted` is 1, all inputs are ignored until `rst`.
- R11: If a valid software error report and `hs_req` arrive in the same cycle, the error wins: the attempt fails and `boot_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_clk_ok | input | 1 | Graphics power and clock are good |
| gfx_rst_done | input | 1 | Graphics device has finished its reset |
| link_l0 | input | 1 | Interconnect link is in L0 |
| hs_req | input | 1 | Software asked for the power-up cause |
| sw_err_vld | input | 1 | Software error report strobe |
| sw_err_code | input | 8 | Software error code |
| gfx_reset | output | 1 | Graphics reset, 1 = held in reset |
| cpu_reset | output | 1 | CPU reset, 1 = held in reset |
| boot_done | output | 1 | Handshake received, boot complete |
| err_code | output | 8 | Code of the most recent failure |
| halted | output | 1 | Retries exhausted, block stopped |

## Verification
Every output is a register loaded from the next-state decode. A stage advance or a software failure therefore shows at the ports one cycle after the input is sampled. A timeout shows on the Nth cycle of the wait, and a retry hold lasts exactly HOLD_CYC cycles. The bench drives inputs on falling edges and reads outputs on the next falling edge. It measures each wait and hold by counting falling edges until the reset line changes, and compares the count with the parameter. Random attempt sequences with random response delays are scored against a bench function that gives the expected code for each kind of attempt, and the halt is expected on the fifth failure.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  localparam int unsigned CODE_W = 8;

  typedef enum logic [2:0] {
    ST_PWR,   // waiting for power and clock
    ST_HOLD,  // both resets forced between attempts
    ST_GFX,   // graphics released, waiting for reset-done
    ST_LINK,  // waiting for link L0
    ST_HS,    // CPU released, waiting for handshake
    ST_DONE,  // boot finished
    ST_HALT   // retries exhausted
  } seq_st_t;

  localparam logic [CODE_W-1:0] CODE_NO_RSTDONE = 8'h08;
  localparam logic [CODE_W-1:0] CODE_NO_L0      = 8'h09;
  localparam logic [CODE_W-1:0] CODE_NO_HS      = 8'h0A;
  localparam logic [CODE_W-1:0] SW_CODE_LO      = 8'h10;
  localparam logic [CODE_W-1:0] SW_CODE_HI      = 8'h15;

  localparam int unsigned N_STAGES = 3;
endpackage

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic hit
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  // Cleared whenever the owning state is not active, so it starts at zero on entry.
  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!hit)   cnt <= cnt + 1'b1;
  end

  assign hit = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/boot_retry_track.sv
module boot_retry_track #(
  parameter int unsigned MAX_RETRY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fail,
  output logic last
);
  localparam int unsigned RW = $clog2(MAX_RETRY + 1);

  logic [RW-1:0] used;

  always_ff @(posedge clk) begin
    if (rst)               used <= '0;
    else if (fail && !last) used <= used + 1'b1;
  end

  assign last = (used == RW'(MAX_RETRY));
endmodule

// File: rtl/boot_sw_err_check.sv
module boot_sw_err_check
  import boot_seq_pkg::*;
(
  input  logic              vld,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  assign hit = vld && (code >= SW_CODE_LO) && (code <= SW_CODE_HI);
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
#(
  parameter int unsigned GFX_TMO   = 4096,
  parameter int unsigned LINK_TMO  = 8192,
  parameter int unsigned HS_TMO    = 65536,
  parameter int unsigned HOLD_CYC  = 64,
  parameter int unsigned MAX_RETRY = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_clk_ok,
  input  logic              gfx_rst_done,
  input  logic              link_l0,
  input  logic              hs_req,
  input  logic              sw_err_vld,
  input  logic [CODE_W-1:0] sw_err_code,
  output logic              gfx_reset,
  output logic              cpu_reset,
  output logic              boot_done,
  output logic [CODE_W-1:0] err_code,
  output logic              halted
);
  localparam int unsigned TMO [N_STAGES] = '{GFX_TMO, LINK_TMO, HS_TMO};

  seq_st_t state, nxt;
  logic [N_STAGES-1:0] stage_run, tmo_hit;
  logic hold_hit, last_try, sw_hit, fail;
  logic [CODE_W-1:0] fail_code;

  assign stage_run = {state == ST_HS, state == ST_LINK, state == ST_GFX};

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage_tmr
    boot_wait_timer #(.LIMIT(TMO[g])) u_tmr (
      .clk (clk),
      .rst (rst),
      .run (stage_run[g]),
      .hit (tmo_hit[g])
    );
  end

  boot_wait_timer #(.LIMIT(HOLD_CYC)) u_hold (
    .clk (clk),
    .rst (rst),
    .run (state == ST_HOLD),
    .hit (hold_hit)
  );

  boot_retry_track #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk  (clk),
    .rst  (rst),
    .fail (fail),
    .last (last_try)
  );

  boot_sw_err_check u_swchk (
    .vld  (sw_err_vld),
    .code (sw_err_code),
    .hit  (sw_hit)
  );

  always_comb begin
    nxt       = state;
    fail      = 1'b0;
    fail_code = '0;
    unique case (state)
      ST_PWR:  if (pwr_clk_ok) nxt = ST_GFX;
      ST_HOLD: if (hold_hit && pwr_clk_ok) nxt = ST_GFX;
      ST_GFX: begin
        if (gfx_rst_done) nxt = ST_LINK;
        else if (tmo_hit[0]) begin fail = 1'b1; fail_code = CODE_NO_RSTDONE; end
      end
      ST_LINK: begin
        if (link_l0) nxt = ST_HS;
        else if (tmo_hit[1]) begin fail = 1'b1; fail_code = CODE_NO_L0; end
      end
      ST_HS: begin
        // a software failure report outranks a handshake in the same cycle
        if (sw_hit) begin fail = 1'b1; fail_code = sw_err_code; end
        else if (hs_req) nxt = ST_DONE;
        else if (tmo_hit[2]) begin fail = 1'b1; fail_code = CODE_NO_HS; end
      end
      default: nxt = state;
    endcase
    if (fail) nxt = last_try ? ST_HALT : ST_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_PWR;
      gfx_reset <= 1'b1;
      cpu_reset <= 1'b1;
      boot_done <= 1'b0;
      halted    <= 1'b0;
      err_code  <= '0;
    end else begin
      state     <= nxt;
      gfx_reset <= !(nxt inside {ST_GFX, ST_LINK, ST_HS, ST_DONE});
      cpu_reset <= !(nxt inside {ST_HS, ST_DONE});
      boot_done <= (nxt == ST_DONE);
      halted    <= (nxt == ST_HALT);
      if (fail) err_code <= fail_code;
    end
  end
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk
  import boot_seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              pwr_clk_ok,
  input logic              link_l0,
  input logic              gfx_reset,
  input logic              cpu_reset,
  input logic              boot_done,
  input logic [CODE_W-1:0] err_code,
  input logic              halted
);
  a_r2_power_gate: assert property (@(posedge clk) disable iff (rst)
    $fell(gfx_reset) |-> $past(pwr_clk_ok));

  a_r3_cpu_after_gfx: assert property (@(posedge clk) disable iff (rst)
    !cpu_reset |-> !gfx_reset);

  a_r4_cpu_needs_l0: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_reset) |-> $past(link_l0));

  a_r5_code_on_fail: assert property (@(posedge clk) disable iff (rst)
    $rose(gfx_reset) |-> (err_code != '0));

  a_r7_halt_resets: assert property (@(posedge clk) disable iff (rst)
    halted |-> (gfx_reset && cpu_reset && !boot_done));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    boot_done |=> (boot_done && !gfx_reset && !cpu_reset && $stable(err_code)));

  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(err_code)));
endmodule

bind boot_seq_ctrl boot_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwr_clk_ok (pwr_clk_ok),
  .link_l0    (link_l0),
  .gfx_reset  (gfx_reset),
  .cpu_reset  (cpu_reset),
  .boot_done  (boot_done),
  .err_code   (err_code),
  .halted     (halted)
);

// File: tb/sim_boot_seq_ctrl.sv
module sim_boot_seq_ctrl;
  localparam int TG = 20, TL = 24, TH = 28, HC = 6, MR = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic pwr = 1'b0, rdone = 1'b0, l0 = 1'b0, hs = 1'b0, sev = 1'b0;
  logic [7:0] sec = 8'h00;
  logic gfx_reset, cpu_reset, boot_done, halted;
  logic [7:0] err_code;

  int checks = 0, fails = 0;
  bit fin = 1'b0;
  logic [7:0] exp_err = 8'h00;

  always #2 clk = ~clk;

  boot_seq_ctrl #(.GFX_TMO(TG), .LINK_TMO(TL), .HS_TMO(TH), .HOLD_CYC(HC), .MAX_RETRY(MR)) u0 (
    .clk(clk), .rst(rst), .pwr_clk_ok(pwr), .gfx_rst_done(rdone), .link_l0(l0),
    .hs_req(hs), .sw_err_vld(sev), .sw_err_code(sec),
    .gfx_reset(gfx_reset), .cpu_reset(cpu_reset), .boot_done(boot_done),
    .err_code(err_code), .halted(halted));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  // kinds: 0 no reset-done, 1 no L0, 2 no handshake, 3 sw error,
  //        4 success, 5 bad sw codes then success, 6 sw error together with handshake
  function automatic logic [7:0] exp_code(input int kind, input logic [7:0] swc);
    case (kind)
      0: return 8'h08;
      1: return 8'h09;
      2: return 8'h0A;
      3, 6: return swc;
      default: return 8'h00;
    endcase
  endfunction

  task automatic do_reset();
    rst = 1'b1; pwr = 0; rdone = 0; l0 = 0; hs = 0; sev = 0; sec = 0;
    exp_err = 8'h00;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic start();
    pwr = 1'b1;
    tick();
    chk("R3", "gfx released after power", gfx_reset, 0);
    chk("R3", "cpu held after power", cpu_reset, 1);
  endtask

  task automatic count_while(input bit want_gfx, input logic val, output int n);
    n = 0;
    while (((want_gfx ? gfx_reset : cpu_reset) == val) && n < 2000) begin
      n++; tick();
    end
  endtask

  // called at the first falling edge of an attempt (graphics just released)
  task automatic attempt(input int kind, input logic [7:0] swc, output bit failed);
    int n;
    failed = 1'b1;
    if (kind == 0) begin
      count_while(1'b1, 1'b0, n);
      chk("R5", "reset-done wait length", n, TG);
    end else begin
      repeat ($urandom % (TG - 2)) tick();
      rdone = 1'b1; tick(); rdone = 1'b0;
      chk("R3", "cpu held until L0", cpu_reset, 1);
      chk("R3", "gfx still released", gfx_reset, 0);
      if (kind == 1) begin
        count_while(1'b1, 1'b0, n);
        chk("R5", "L0 wait length", n, TL);
      end else begin
        repeat ($urandom % (TL - 2)) tick();
        l0 = 1'b1; tick(); l0 = 1'b0;
        chk("R4", "cpu released after L0", cpu_reset, 0);
        if (kind == 2) begin
          count_while(1'b0, 1'b0, n);
          chk("R5", "handshake wait length", n, TH);
        end else begin
          repeat ($urandom % (TH - 4)) tick();
          if (kind == 5) begin
            sev = 1'b1; sec = 8'h16; tick();
            sec = 8'h0F; tick(); sev = 1'b0;
            chk("R8", "out-of-range codes ignored cpu", cpu_reset, 0);
            chk("R8", "out-of-range codes keep err", err_code, exp_err);
          end
          if (kind == 3 || kind == 6) begin
            sev = 1'b1; sec = swc; hs = (kind == 6); tick(); sev = 1'b0; hs = 1'b0;
            chk(kind == 6 ? "R11" : "R8", "sw error resets cpu", cpu_reset, 1);
            chk(kind == 6 ? "R11" : "R8", "sw error resets gfx", gfx_reset, 1);
            if (kind == 6) chk("R11", "no done on tie", boot_done, 0);
          end else begin
            hs = 1'b1; tick(); hs = 1'b0;
            chk("R4", "done after handshake", boot_done, 1);
            failed = 1'b0;
          end
        end
      end
    end
    if (failed) begin
      exp_err = exp_code(kind, swc);
      chk("R5", "failure code", err_code, exp_err);
    end
  endtask

  task automatic after_fail(input int idx);
    int n;
    if (idx == MR + 1) begin
      chk("R7", "halted after last attempt", halted, 1);
      chk("R7", "resets held when halted", {gfx_reset, cpu_reset}, 3);
      chk("R7", "final code", err_code, exp_err);
    end else begin
      chk("R7", "not halted early", halted, 0);
      count_while(1'b1, 1'b1, n);
      chk("R6", "retry hold length", n, HC);
      chk("R6", "restart holds cpu", cpu_reset, 1);
    end
  endtask

  task automatic run_seq(input int k0, k1, k2, k3, k4, input logic [7:0] swc);
    int ks[5];
    bit f;
    ks = '{k0, k1, k2, k3, k4};
    do_reset(); start();
    for (int i = 0; i < 5; i++) begin
      attempt(ks[i], swc, f);
      if (!f) break;
      after_fail(i + 1);
    end
  endtask

  task automatic poke_random(input int cycles, input bit in_done);
    for (int i = 0; i < cycles; i++) begin
      pwr = $urandom; rdone = $urandom; l0 = $urandom; hs = $urandom;
      sev = $urandom; sec = 8'h10 + 8'($urandom % 6);
      tick();
      if (in_done) begin
        chk("R9", "done holds", boot_done, 1);
        chk("R9", "resets stay released", {gfx_reset, cpu_reset}, 0);
        chk("R9", "code unchanged", err_code, exp_err);
      end else begin
        chk("R10", "halt holds", halted, 1);
        chk("R10", "resets stay asserted", {gfx_reset, cpu_reset}, 3);
        chk("R10", "code unchanged", err_code, exp_err);
      end
    end
    pwr = 1; rdone = 0; l0 = 0; hs = 0; sev = 0;
  endtask

  initial begin
    bit f;
    void'($urandom(32'd4242));
    do_reset();
    tick();
    chk("R1", "reset gfx", gfx_reset, 1);
    chk("R1", "reset cpu", cpu_reset, 1);
    chk("R1", "reset done", boot_done, 0);
    chk("R1", "reset halt", halted, 0);
    chk("R1", "reset code", err_code, 0);
    repeat (40) tick();
    chk("R2", "no power keeps gfx reset", gfx_reset, 1);
    chk("R2", "no power keeps cpu reset", cpu_reset, 1);

    // clean boot then ignore everything
    start();
    attempt(4, 8'h00, f);
    poke_random(30, 1'b1);

    // each stage exhausted on its own
    run_seq(0, 0, 0, 0, 0, 8'h00); poke_random(20, 1'b0);
    run_seq(1, 1, 1, 1, 1, 8'h00);
    run_seq(2, 2, 2, 2, 2, 8'h00);
    run_seq(3, 3, 3, 3, 3, 8'h12);
    // count carries across mixed failure kinds; priority on the last one
    run_seq(0, 1, 2, 3, 6, 8'h13);
    chk("R7", "mixed kinds halt", halted, 1);
    // four failures then success; ignored bad codes on the way
    run_seq(0, 3, 1, 2, 5, 8'h10);
    chk("R7", "fifth attempt may succeed", boot_done, 1);
    chk("R7", "no halt on success", halted, 0);

    // random campaigns
    for (int r = 0; r < 8; r++) begin
      do_reset(); start();
      for (int i = 0; i < 5; i++) begin
        int k;
        k = (($urandom % 8) == 0) ? 4 : int'($urandom % 7);
        attempt(k, 8'h10 + 8'($urandom % 6), f);
        if (!f) begin
          chk("R4", "random success done", boot_done, 1);
          break;
        end
        after_fail(i + 1);
      end
    end

    fin = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule